// File: doc/BRIEF.md
# Stack Operation Address and Writeback Unit

This block is the execute-stage slice of a 64-bit load/store pipeline that turns the four stack instructions (push, pop, call and return) into a memory access and a pair of register writebacks. It also covers plain displacement loads and stores. For the stack group it ignores the base register operand and uses the stack pointer instead, and it replaces the immediate displacement with a fixed step of one machine word (8 bytes by default). The result is an effective memory address, store data, read/write strobes, and two destination register IDs: one for the ALU result and one for the loaded value. A control redirect goes with call and return.

Push and call move the pointer down first and address memory at the new pointer. Pop and return address memory at the old pointer and move it up afterwards. Call stores its fall-through PC and redirects to its immediate target. Return redirects to the word it loads. Pop writes two registers. When its destination is the stack pointer itself, the loaded value is the one that lands: the unit drops the pointer-adjust write.

Decoded fields are captured at a clock edge into the execute/memory boundary register. Loaded data from the memory array comes back combinationally in the following cycle and is steered to the memory-result writeback value and to the return target.

Top module: `stk_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid operation, `mem_rd`, `mem_wr` and `redirect_valid` are 0, both destination IDs are 15 (the "no register" code), and `mem_addr`, `mem_wdata`, `dst_e_val` are 0.
- R2: Push (opcode 3) sets `mem_addr` to the stack pointer minus 8 (modulo 2^64), `mem_wdata` to the source operand, `mem_wr`=1, `dst_e_id`=4 (the stack-pointer register), `dst_e_val`=`mem_addr`, and `dst_m_id`=15. For example, a stack pointer of 0x100 with a value of 3 gives address 0xf8, store data 3 and a new pointer of 0xf8.
- R3: Pop (opcode 4) sets `mem_addr` to the unadjusted stack pointer, `mem_rd`=1, `dst_e_id`=4 with `dst_e_val` = pointer plus 8, `dst_m_id` = the `in_ra` register ID, and `dst_m_val` = `mem_rdata`.
- R4: Pop with `in_ra`=4 drives `dst_e_id`=15 and `dst_m_id`=4, so the loaded value, not the adjusted pointer, is written to the stack pointer. `dst_e_val` still carries pointer plus 8.
- R5: Call (opcode 5) addresses and adjusts like push, but stores `in_fallthru`. It asserts `redirect_valid` with `redirect_pc` = `in_disp`.
- R6: Return (opcode 6) addresses and adjusts like pop with `dst_m_id`=15. It asserts `redirect_valid` with `redirect_pc` = `mem_rdata`.
- R7: Load (opcode 1) and store (opcode 2) address `in_rb_val + in_disp` and ignore `in_sp`. A load reads with `dst_m_id`=`in_ra`. A store writes `in_ra_val`. Both have `dst_e_id`=15.
- R8: With `in_valid`=0, or with opcode 0 or any opcode from 7 to 15, no strobe or redirect is raised, both IDs are 15, and all data outputs are 0.
- R9: Decoded outputs appear one clock after the inputs are sampled. `dst_m_val` (equal to `mem_rdata` while `mem_rd` is 1, else 0) and the return `redirect_pc` follow `mem_rdata` in the same cycle without a clock edge.
- R10: `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded operation present this cycle |
| in_op | input | 4 | Operation code (0 none, 1 load, 2 store, 3 push, 4 pop, 5 call, 6 return) |
| in_ra | input | 4 | First register specifier (source of push/store, destination of pop/load) |
| in_sp | input | 64 | Current stack-pointer value |
| in_ra_val | input | 64 | Value of the first register operand |
| in_rb_val | input | 64 | Base register value for load/store |
| in_disp | input | 64 | Immediate: displacement for load/store, target for call |
| in_fallthru | input | 64 | Address of the next sequential instruction |
| mem_rdata | input | 64 | Loaded word returned by memory in the output cycle |
| mem_addr | output | 64 | Effective memory address |
| mem_wdata | output | 64 | Store data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dst_e_id | output | 4 | ALU-result destination register ID (15 = none) |
| dst_e_val | output | 64 | ALU-result value (adjusted pointer or effective address) |
| dst_m_id | output | 4 | Memory-result destination register ID (15 = none) |
| dst_m_val | output | 64 | Memory-result value |
| redirect_valid | output | 1 | Control transfer requested |
| redirect_pc | output | 64 | Control transfer target |

## Verification
Each of the six opcodes is driven with pointer and operand values that make new-pointer and old-pointer addressing give different numbers. A swapped address choice, a wrong step sign or a wrong store source therefore shows in `mem_addr` or `mem_wdata`. Push at pointer 0 checks the modulo wrap, and load/store with a pointer that differs from the base checks that the base mux follows the opcode. Pop into register 4 separates the priority case from ordinary pop, and pop into register 2 shows that the pointer write is suppressed only in that case. Idle and undefined opcodes confirm that nothing leaks out. Changing `mem_rdata` between clock edges shows the load path is combinational.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [3:0] {
      OP_NONE  = 4'd0,
      OP_LOAD  = 4'd1,
      OP_STORE = 4'd2,
      OP_PUSH  = 4'd3,
      OP_POP   = 4'd4,
      OP_CALL  = 4'd5,
      OP_RET   = 4'd6
   } stk_op_e;

   typedef enum logic [1:0] {
      WS_ZERO = 2'd0,
      WS_RA   = 2'd1,
      WS_FT   = 2'd2
   } wsrc_e;

   typedef enum logic [1:0] {
      DE_NONE  = 2'd0,
      DE_SP    = 2'd1,
      DE_YIELD = 2'd2
   } dste_e;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_IMM  = 2'd1,
      RD_LOAD = 2'd2
   } redir_e;

   typedef struct packed {
      logic   act;
      logic   use_sp;
      logic   sp_dec;
      logic   addr_sum;
      logic   rd;
      logic   wr;
      wsrc_e  wsrc;
      dste_e  dste;
      logic   dstm_ra;
      redir_e redir;
   } stk_ctrl_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
   import stk_pkg::*;
(
   input  logic            valid,
   input  logic [3:0]      op,
   output stk_ctrl_t       ctrl
);

   always_comb begin
      ctrl = '0;
      if (valid) begin
         case (op)
            OP_LOAD: begin
               ctrl.act      = 1'b1;
               ctrl.addr_sum = 1'b1;
               ctrl.rd       = 1'b1;
               ctrl.dstm_ra  = 1'b1;
            end
            OP_STORE: begin
               ctrl.act      = 1'b1;
               ctrl.addr_sum = 1'b1;
               ctrl.wr       = 1'b1;
               ctrl.wsrc     = WS_RA;
            end
            OP_PUSH: begin
               ctrl.act      = 1'b1;
               ctrl.use_sp   = 1'b1;
               ctrl.sp_dec   = 1'b1;
               ctrl.addr_sum = 1'b1;
               ctrl.wr       = 1'b1;
               ctrl.wsrc     = WS_RA;
               ctrl.dste     = DE_SP;
            end
            OP_POP: begin
               ctrl.act      = 1'b1;
               ctrl.use_sp   = 1'b1;
               ctrl.rd       = 1'b1;
               ctrl.dste     = DE_YIELD;
               ctrl.dstm_ra  = 1'b1;
            end
            OP_CALL: begin
               ctrl.act      = 1'b1;
               ctrl.use_sp   = 1'b1;
               ctrl.sp_dec   = 1'b1;
               ctrl.addr_sum = 1'b1;
               ctrl.wr       = 1'b1;
               ctrl.wsrc     = WS_FT;
               ctrl.dste     = DE_SP;
               ctrl.redir    = RD_IMM;
            end
            OP_RET: begin
               ctrl.act      = 1'b1;
               ctrl.use_sp   = 1'b1;
               ctrl.rd       = 1'b1;
               ctrl.dste     = DE_SP;
               ctrl.redir    = RD_LOAD;
            end
            default: ctrl = '0;
         endcase
      end
   end

   always_comb begin
      if (valid && ctrl.act) begin
         assert (!(ctrl.rd && ctrl.wr))
            else $error("AST_DEC_RW_EXCL"); // R10
      end
   end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
   import stk_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int STEP_BYTES  = XLEN / 8,
   parameter int ADDER_STYLE = 0
) (
   input  stk_ctrl_t        ctrl,
   input  logic [XLEN-1:0]  sp,
   input  logic [XLEN-1:0]  base_val,
   input  logic [XLEN-1:0]  disp,
   output logic [XLEN-1:0]  addr,
   output logic [XLEN-1:0]  adj
);

   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP_BYTES);
   localparam logic [XLEN-1:0] NSTEP_V = '0 - STEP_V;

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] old_base;

   generate
      if (ADDER_STYLE == 0) begin : g_shared
         logic [XLEN-1:0] opnd_a;
         logic [XLEN-1:0] opnd_b;
         always_comb begin
            opnd_a = ctrl.use_sp ? sp : base_val;
            if (ctrl.use_sp) opnd_b = ctrl.sp_dec ? NSTEP_V : STEP_V;
            else             opnd_b = disp;
            sum      = opnd_a + opnd_b;
            old_base = opnd_a;
         end
      end else begin : g_split
         logic [XLEN-1:0] sp_down;
         logic [XLEN-1:0] sp_up;
         logic [XLEN-1:0] gen_ea;
         always_comb begin
            sp_down  = sp - STEP_V;
            sp_up    = sp + STEP_V;
            gen_ea   = base_val + disp;
            if (ctrl.use_sp) sum = ctrl.sp_dec ? sp_down : sp_up;
            else             sum = gen_ea;
            old_base = ctrl.use_sp ? sp : base_val;
         end
      end
   endgenerate

   always_comb begin
      if (ctrl.act) begin
         addr = ctrl.addr_sum ? sum : old_base;
         adj  = sum;
      end else begin
         addr = '0;
         adj  = '0;
      end
   end

endmodule

// File: rtl/stk_dest_sel.sv
module stk_dest_sel
   import stk_pkg::*;
#(
   parameter int RID_W   = 4,
   parameter int SP_ID   = 4,
   parameter int NONE_ID = 15
) (
   input  stk_ctrl_t         ctrl,
   input  logic [RID_W-1:0]  ra,
   output logic [RID_W-1:0]  de_id,
   output logic [RID_W-1:0]  dm_id
);

   localparam logic [RID_W-1:0] SP_V   = RID_W'(SP_ID);
   localparam logic [RID_W-1:0] NONE_V = RID_W'(NONE_ID);

   always_comb begin
      case (ctrl.dste)
         DE_SP:    de_id = SP_V;
         DE_YIELD: de_id = (ctrl.dstm_ra && ra == SP_V) ? NONE_V : SP_V;
         default:  de_id = NONE_V;
      endcase
      dm_id = ctrl.dstm_ra ? ra : NONE_V;
   end

endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
   import stk_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int RID_W       = 4,
   parameter int SP_ID       = 4,
   parameter int NONE_ID     = 15,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [RID_W-1:0]  in_ra,
   input  logic [XLEN-1:0]   in_sp,
   input  logic [XLEN-1:0]   in_ra_val,
   input  logic [XLEN-1:0]   in_rb_val,
   input  logic [XLEN-1:0]   in_disp,
   input  logic [XLEN-1:0]   in_fallthru,
   input  logic [XLEN-1:0]   mem_rdata,
   output logic [XLEN-1:0]   mem_addr,
   output logic [XLEN-1:0]   mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [RID_W-1:0]  dst_e_id,
   output logic [XLEN-1:0]   dst_e_val,
   output logic [RID_W-1:0]  dst_m_id,
   output logic [XLEN-1:0]   dst_m_val,
   output logic              redirect_valid,
   output logic [XLEN-1:0]   redirect_pc
);

   localparam int              STEP_BYTES = XLEN / 8;
   localparam logic [XLEN-1:0] STEP_V     = XLEN'(STEP_BYTES);
   localparam logic [RID_W-1:0] SP_V      = RID_W'(SP_ID);
   localparam logic [RID_W-1:0] NONE_V    = RID_W'(NONE_ID);

   generate
      if (XLEN < 16 || (XLEN % 8) != 0) begin : g_bad_xlen
         $error("XLEN must be a multiple of 8 and at least 16");
      end
      if (SP_ID < 0 || SP_ID >= (1 << RID_W) || NONE_ID < 0 || NONE_ID >= (1 << RID_W)) begin : g_bad_id
         $error("register IDs must fit in RID_W bits");
      end
      if (SP_ID == NONE_ID) begin : g_id_clash
         $error("stack-pointer ID must differ from the no-register ID");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   stk_ctrl_t        ctrl;
   logic [XLEN-1:0]  addr_c;
   logic [XLEN-1:0]  adj_c;
   logic [RID_W-1:0] de_c;
   logic [RID_W-1:0] dm_c;
   logic [XLEN-1:0]  wdata_c;

   stk_decode u_dec (
      .valid (in_valid),
      .op    (in_op),
      .ctrl  (ctrl)
   );

   stk_addr_gen #(
      .XLEN        (XLEN),
      .STEP_BYTES  (STEP_BYTES),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_agen (
      .ctrl     (ctrl),
      .sp       (in_sp),
      .base_val (in_rb_val),
      .disp     (in_disp),
      .addr     (addr_c),
      .adj      (adj_c)
   );

   stk_dest_sel #(
      .RID_W   (RID_W),
      .SP_ID   (SP_ID),
      .NONE_ID (NONE_ID)
   ) u_dsel (
      .ctrl  (ctrl),
      .ra    (in_ra),
      .de_id (de_c),
      .dm_id (dm_c)
   );

   always_comb begin
      case (ctrl.wsrc)
         WS_RA:   wdata_c = in_ra_val;
         WS_FT:   wdata_c = in_fallthru;
         default: wdata_c = '0;
      endcase
   end

   // execute/memory boundary register
   logic [XLEN-1:0]  addr_q;
   logic [XLEN-1:0]  wdata_q;
   logic             rd_q;
   logic             wr_q;
   logic [RID_W-1:0] de_q;
   logic [XLEN-1:0]  dev_q;
   logic [RID_W-1:0] dm_q;
   redir_e           redir_q;
   logic [XLEN-1:0]  tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
         de_q    <= NONE_V;
         dev_q   <= '0;
         dm_q    <= NONE_V;
         redir_q <= RD_NONE;
         tgt_q   <= '0;
      end else begin
         addr_q  <= addr_c;
         wdata_q <= wdata_c;
         rd_q    <= ctrl.rd;
         wr_q    <= ctrl.wr;
         de_q    <= de_c;
         dev_q   <= adj_c;
         dm_q    <= dm_c;
         redir_q <= ctrl.redir;
         tgt_q   <= (ctrl.redir == RD_IMM) ? in_disp : '0;
      end
   end

   always_comb begin
      mem_addr       = addr_q;
      mem_wdata      = wdata_q;
      mem_rd         = rd_q;
      mem_wr         = wr_q;
      dst_e_id       = de_q;
      dst_e_val      = dev_q;
      dst_m_id       = dm_q;
      dst_m_val      = rd_q ? mem_rdata : '0;
      redirect_valid = (redir_q != RD_NONE);
      case (redir_q)
         RD_IMM:  redirect_pc = tgt_q;
         RD_LOAD: redirect_pc = mem_rdata;
         default: redirect_pc = '0;
      endcase
   end

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !mem_wr) else $error("AST_RW_EXCL"); // R10

   AST_PUSH_NEW_SP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_PUSH) |=>
         (mem_addr == $past(in_sp) - STEP_V) && (dst_e_val == mem_addr) && (dst_e_id == SP_V))
      else $error("AST_PUSH_NEW_SP"); // R2

   AST_POP_OLD_SP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_POP) |=>
         (mem_addr == $past(in_sp)) && (mem_addr + STEP_V == dst_e_val) && mem_rd)
      else $error("AST_POP_OLD_SP"); // R3

   AST_POP_SP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_POP && in_ra == SP_V) |=>
         (dst_e_id == NONE_V) && (dst_m_id == SP_V))
      else $error("AST_POP_SP_WINS"); // R4

   AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == OP_CALL) |=>
         redirect_valid && (redirect_pc == $past(in_disp)) && (mem_wdata == $past(in_fallthru)))
      else $error("AST_CALL_TARGET"); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!mem_rd && !mem_wr && !redirect_valid && dst_e_id == NONE_V && dst_m_id == NONE_V))
      else $error("AST_IDLE_QUIET"); // R8

endmodule

// File: tb/stk_exec_unit_tb.sv
module stk_exec_unit_tb;

   typedef struct packed {
      logic [15:0] tag;
      logic [3:0]  op;
      logic [3:0]  ra;
      logic [63:0] sp;
      logic [63:0] rav;
      logic [63:0] rbv;
      logic [63:0] disp;
      logic [63:0] ft;
      logic [63:0] rdata;
      logic [63:0] e_addr;
      logic [63:0] e_wdata;
      logic        e_rd;
      logic        e_wr;
      logic [3:0]  e_de;
      logic [63:0] e_ve;
      logic [3:0]  e_dm;
      logic [63:0] e_vm;
      logic        e_rv;
      logic [63:0] e_rpc;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // push 3 at pointer 0x100
      '{"R2", 4'd3, 4'd0, 64'h100, 64'h3, 64'h0, 64'h0, 64'h0, 64'h0,
        64'hf8, 64'h3, 1'b0, 1'b1, 4'd4, 64'hf8, 4'd15, 64'h0, 1'b0, 64'h0},
      // push at pointer 0 wraps
      '{"R2", 4'd3, 4'd1, 64'h0, 64'hdead, 64'h0, 64'h0, 64'h0, 64'h0,
        64'hffff_ffff_ffff_fff8, 64'hdead, 1'b0, 1'b1, 4'd4, 64'hffff_ffff_ffff_fff8, 4'd15, 64'h0, 1'b0, 64'h0},
      // pop into r2 at pointer 4
      '{"R3", 4'd4, 4'd2, 64'h4, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0fb0_0000_0000_0000,
        64'h4, 64'h0, 1'b1, 1'b0, 4'd4, 64'hc, 4'd2, 64'h0fb0_0000_0000_0000, 1'b0, 64'h0},
      // pop into the stack pointer
      '{"R4", 4'd4, 4'd4, 64'h200, 64'h0, 64'h0, 64'h0, 64'h0, 64'h55,
        64'h200, 64'h0, 1'b1, 1'b0, 4'd15, 64'h208, 4'd4, 64'h55, 1'b0, 64'h0},
      // call
      '{"R5", 4'd5, 4'd0, 64'h100, 64'h0, 64'h0, 64'h20, 64'h13, 64'h0,
        64'hf8, 64'h13, 1'b0, 1'b1, 4'd4, 64'hf8, 4'd15, 64'h0, 1'b1, 64'h20},
      // return
      '{"R6", 4'd6, 4'd0, 64'h100, 64'h0, 64'h0, 64'h0, 64'h0, 64'h20,
        64'h100, 64'h0, 1'b1, 1'b0, 4'd4, 64'h108, 4'd15, 64'h20, 1'b1, 64'h20},
      // load r3 from 0x1000+0x18
      '{"R7", 4'd1, 4'd3, 64'h100, 64'h0, 64'h1000, 64'h18, 64'h0, 64'h77,
        64'h1018, 64'h0, 1'b1, 1'b0, 4'd15, 64'h1018, 4'd3, 64'h77, 1'b0, 64'h0},
      // store r5 to 0x2000-8
      '{"R7", 4'd2, 4'd5, 64'h100, 64'habc, 64'h2000, 64'hffff_ffff_ffff_fff8, 64'h0, 64'h0,
        64'h1ff8, 64'habc, 1'b0, 1'b1, 4'd15, 64'h1ff8, 4'd15, 64'h0, 1'b0, 64'h0},
      // no-op
      '{"R8", 4'd0, 4'd2, 64'h100, 64'h5, 64'h7, 64'h9, 64'h11, 64'h33,
        64'h0, 64'h0, 1'b0, 1'b0, 4'd15, 64'h0, 4'd15, 64'h0, 1'b0, 64'h0},
      // undefined opcode 9
      '{"R8", 4'd9, 4'd2, 64'h100, 64'h5, 64'h7, 64'h9, 64'h11, 64'h33,
        64'h0, 64'h0, 1'b0, 1'b0, 4'd15, 64'h0, 4'd15, 64'h0, 1'b0, 64'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [3:0]  in_op;
   logic [3:0]  in_ra;
   logic [63:0] in_sp, in_ra_val, in_rb_val, in_disp, in_fallthru, mem_rdata;
   logic [63:0] mem_addr, mem_wdata, dst_e_val, dst_m_val, redirect_pc;
   logic        mem_rd, mem_wr, redirect_valid;
   logic [3:0]  dst_e_id, dst_m_id;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   stk_exec_unit u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_op          (in_op),
      .in_ra          (in_ra),
      .in_sp          (in_sp),
      .in_ra_val      (in_ra_val),
      .in_rb_val      (in_rb_val),
      .in_disp        (in_disp),
      .in_fallthru    (in_fallthru),
      .mem_rdata      (mem_rdata),
      .mem_addr       (mem_addr),
      .mem_wdata      (mem_wdata),
      .mem_rd         (mem_rd),
      .mem_wr         (mem_wr),
      .dst_e_id       (dst_e_id),
      .dst_e_val      (dst_e_val),
      .dst_m_id       (dst_m_id),
      .dst_m_val      (dst_m_val),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [3:0] op, input logic [3:0] ra,
                        input logic [63:0] sp, input logic [63:0] rav, input logic [63:0] rbv,
                        input logic [63:0] dp, input logic [63:0] ft, input logic [63:0] rd);
      in_valid = v; in_op = op; in_ra = ra; in_sp = sp; in_ra_val = rav;
      in_rb_val = rbv; in_disp = dp; in_fallthru = ft; mem_rdata = rd;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b1, 4'd3, 4'd0, 64'h100, 64'h3, 64'h0, 64'h0, 64'h0, 64'h0);
      repeat (3) @(negedge clk);
      // R1: held in reset despite a valid push at the inputs
      chk("R1", "mem_wr",  {63'b0, mem_wr}, 64'h0);
      chk("R1", "mem_rd",  {63'b0, mem_rd}, 64'h0);
      chk("R1", "redir",   {63'b0, redirect_valid}, 64'h0);
      chk("R1", "de_id",   {60'b0, dst_e_id}, 64'd15);
      chk("R1", "dm_id",   {60'b0, dst_m_id}, 64'd15);
      chk("R1", "addr",    mem_addr, 64'h0);
      chk("R1", "e_val",   dst_e_val, 64'h0);
      drive(1'b0, 4'd0, 4'd0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "wdata after reset", mem_wdata, 64'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VECS[i].op, VECS[i].ra, VECS[i].sp, VECS[i].rav, VECS[i].rbv,
               VECS[i].disp, VECS[i].ft, VECS[i].rdata);
         @(negedge clk);
         chk($sformatf("%s", VECS[i].tag), "mem_addr",  mem_addr,  VECS[i].e_addr);
         chk($sformatf("%s", VECS[i].tag), "mem_wdata", mem_wdata, VECS[i].e_wdata);
         chk($sformatf("%s", VECS[i].tag), "mem_rd", {63'b0, mem_rd}, {63'b0, VECS[i].e_rd});
         chk($sformatf("%s", VECS[i].tag), "mem_wr", {63'b0, mem_wr}, {63'b0, VECS[i].e_wr});
         chk($sformatf("%s", VECS[i].tag), "dst_e_id", {60'b0, dst_e_id}, {60'b0, VECS[i].e_de});
         chk($sformatf("%s", VECS[i].tag), "dst_e_val", dst_e_val, VECS[i].e_ve);
         chk($sformatf("%s", VECS[i].tag), "dst_m_id", {60'b0, dst_m_id}, {60'b0, VECS[i].e_dm});
         chk($sformatf("%s", VECS[i].tag), "dst_m_val", dst_m_val, VECS[i].e_vm);
         chk($sformatf("%s", VECS[i].tag), "redirect_valid", {63'b0, redirect_valid}, {63'b0, VECS[i].e_rv});
         chk($sformatf("%s", VECS[i].tag), "redirect_pc", redirect_pc, VECS[i].e_rpc);
         chk("R10", "rd and wr together", {63'b0, mem_rd & mem_wr}, 64'h0);
      end

      // R8: valid low masks a push
      drive(1'b0, 4'd3, 4'd1, 64'h100, 64'h44, 64'h0, 64'h0, 64'h0, 64'h0);
      @(negedge clk);
      chk("R8", "idle mem_wr", {63'b0, mem_wr}, 64'h0);
      chk("R8", "idle dst_e_id", {60'b0, dst_e_id}, 64'd15);
      chk("R8", "idle mem_addr", mem_addr, 64'h0);

      // R9: loaded value follows memory data between edges
      drive(1'b1, 4'd4, 4'd6, 64'h300, 64'h0, 64'h0, 64'h0, 64'h0, 64'h1111);
      @(negedge clk);
      chk("R9", "pop m_val", dst_m_val, 64'h1111);
      mem_rdata = 64'h2222;
      #1;
      chk("R9", "pop m_val after data change", dst_m_val, 64'h2222);
      chk("R9", "pop address held", mem_addr, 64'h300);
      drive(1'b1, 4'd6, 4'd0, 64'h400, 64'h0, 64'h0, 64'h0, 64'h0, 64'h500);
      @(negedge clk);
      chk("R6", "ret target", redirect_pc, 64'h500);
      mem_rdata = 64'h640;
      #1;
      chk("R9", "ret target after data change", redirect_pc, 64'h640);

      // R4 versus ordinary pop back to back
      drive(1'b1, 4'd4, 4'd4, 64'h40, 64'h0, 64'h0, 64'h0, 64'h0, 64'h9);
      @(negedge clk);
      chk("R4", "pop sp dst_e_id", {60'b0, dst_e_id}, 64'd15);
      drive(1'b1, 4'd4, 4'd3, 64'h40, 64'h0, 64'h0, 64'h0, 64'h0, 64'h9);
      @(negedge clk);
      chk("R3", "pop r3 dst_e_id", {60'b0, dst_e_id}, 64'd4);
      chk("R3", "pop r3 dst_e_val", dst_e_val, 64'h48);

      drive(1'b0, 4'd0, 4'd0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0);
      @(negedge clk);
      finish_run();
   end

endmodule